// File: doc/BRIEF.md
# Desaturation Blanking and Soft-Shutdown Sequencer

This block is the per-side channel controller of a half-bridge gate driver. It takes a gate-on command and a digitised desaturation comparator level. From these it drives four output-stage enables: a main sourcing stage, a boost sourcing stage, a main sinking stage and a soft-shutdown pull-down. Every duration is a parameter counted in clock cycles. At each turn-on the boost stage helps the main stage for a short first interval. Desaturation sensing is then held off for a blanking window, so that the normal collector-voltage fall of the switch is not taken for a fault.

Once blanking has ended, a desaturation level that persists for the deglitch length counts as a real event. Both main stages are then released into high impedance, and only the soft pull-down is enabled for a fixed soft-off period. During that period an active-low sync output is held low. When the period ends, a one-cycle done pulse tells the fault manager to latch a fault. The channel then stays off with the sinking stage enabled, and ignores gate commands until it receives a clear.

An external freeze input holds the last effective gate command when it is asserted. Desaturation detection keeps working while the channel is frozen.

Top module: `desat_ssd_channel`

## Requirements
- R1: After reset the sinking enable is 1, and the sourcing, boost and soft-off enables, ssd_active_n low and ssd_done are all inactive (src_main=0, src_boost=0, snk_main=1, soft_off=0, ssd_active_n=1, ssd_done=0).
- R2: The clock edge that samples an off-to-on gate command turns on src_main_en and src_boost_en and turns off snk_main_en. Boost stays on for exactly BOOST_CYC cycles, and then only the main sourcing stage remains on.
- R3: The blanking window starts again at every turn-on. If desat_raw is held high from the turn-on cycle, soft_off_en first rises after the (BLANK_CYC+FILT_CYC+1)-th edge counted from the edge that sampled the turn-on, and not before.
- R4: While the channel is off, a high desat_raw has no effect: the outputs stay in the off pattern.
- R5: A desat_raw pulse in the on state that lasts fewer than FILT_CYC consecutive cycles is discarded. A run of exactly FILT_CYC cycles starts soft-off after its last sampled cycle.
- R6: During soft-off, src_main_en, src_boost_en and snk_main_en are all 0, soft_off_en is 1 and ssd_active_n is 0, for exactly SSD_CYC cycles.
- R7: The edge that ends soft-off raises ssd_done for one cycle and enables snk_main_en. After that the gate command is ignored until fault_clr is sampled high. A fault_clr during soft-off has no effect.
- R8: While freeze is high, the channel keeps acting on the gate command it last accepted, whatever gate_on does. A desaturation event is still detected and acted on while frozen.
- R9: If the gate command drops during blanking, the channel returns to the off pattern on the next edge with no event.
- R10: Changes of gate_on during soft-off do not shorten or alter the soft-off period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_on | input | 1 | Gate command, 1 = switch on |
| desat_raw | input | 1 | Digitised desaturation comparator level |
| freeze | input | 1 | Hold the last accepted gate command |
| fault_clr | input | 1 | Clear from the fault manager; leaves the latched-off state |
| src_main_en | output | 1 | Main sourcing stage enable |
| src_boost_en | output | 1 | Boost sourcing stage enable |
| snk_main_en | output | 1 | Main sinking stage enable |
| soft_off_en | output | 1 | Soft-shutdown pull-down enable |
| ssd_active_n | output | 1 | Low while soft-off runs |
| ssd_done | output | 1 | One-cycle pulse at the end of soft-off |

## Verification
A wrong blanking or deglitch count shows up as soft_off_en rising one or more cycles before or after the computed edge. A wrong soft-off timer shows up as a soft-off run of the wrong length, or as ssd_done in the wrong cycle. A state that fails to latch is exposed within one cycle: a held gate command turns the sourcing stage back on where the bench expects the off pattern. Because every output is a decode of registered state, each of these errors is visible in the cycle right after the edge that went wrong.

// File: rtl/desat_ssd_pkg.sv
`timescale 1ns/1ps
package desat_ssd_pkg;
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BLANK = 3'd1,
        ST_ON    = 3'd2,
        ST_SSD   = 3'd3,
        ST_LATCH = 3'd4
    } chan_st_e;
endpackage

// File: rtl/desat_ssd_timer.sv
`timescale 1ns/1ps
// Saturating up-counter that restarts from zero on request.
module desat_ssd_timer #(
    parameter int MAX_CNT = 1000,
    localparam int CW = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart)
            cnt_d = '0;
        else if (cnt_q != CW'(MAX_CNT))
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/desat_ssd_deglitch.sv
`timescale 1ns/1ps
// Minimum-width filter: valid when sample has been high for FILT_CYC enabled cycles.
module desat_ssd_deglitch #(
    parameter int FILT_CYC = 250,
    localparam int FW = $clog2(FILT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sample,
    output logic valid
);
    logic [FW-1:0] run_d, run_q;
    logic          at_last;

    assign at_last = (run_q == FW'(FILT_CYC - 1));

    always_comb begin
        if (!enable || !sample)
            run_d = '0;
        else if (!at_last)
            run_d = run_q + 1'b1;
        else
            run_d = run_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign valid = enable && sample && at_last;
endmodule

// File: rtl/desat_ssd_channel.sv
`timescale 1ns/1ps
// Per-side turn-on / blanking / deglitch / soft-off sequencer.
module desat_ssd_channel
    import desat_ssd_pkg::*;
#(
    parameter int BOOST_CYC = 50,
    parameter int BLANK_CYC = 750,
    parameter int FILT_CYC  = 250,
    parameter int SSD_CYC   = 2312
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on,
    input  logic desat_raw,
    input  logic freeze,
    input  logic fault_clr,
    output logic src_main_en,
    output logic src_boost_en,
    output logic snk_main_en,
    output logic soft_off_en,
    output logic ssd_active_n,
    output logic ssd_done
);
    localparam int TMAX = (BLANK_CYC > SSD_CYC) ? BLANK_CYC : SSD_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        chan_st_e st;
        logic     cmd_hold;
        logic     done;
    } regs_t;

    regs_t         r_d, r_q;
    logic          cmd_eff;
    logic          tmr_restart;
    logic [TW-1:0] tmr_cnt;
    logic          filt_en;
    logic          desat_valid;

    desat_ssd_timer #(.MAX_CNT(TMAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .cnt     (tmr_cnt)
    );

    assign filt_en = (r_q.st == ST_ON);

    desat_ssd_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (filt_en),
        .sample (desat_raw),
        .valid  (desat_valid)
    );

    assign cmd_eff = freeze ? r_q.cmd_hold : gate_on;

    always_comb begin
        r_d          = r_q;
        r_d.cmd_hold = cmd_eff;
        r_d.done     = 1'b0;
        tmr_restart  = 1'b0;
        case (r_q.st)
            ST_OFF: begin
                if (cmd_eff) begin
                    r_d.st      = ST_BLANK;
                    tmr_restart = 1'b1;
                end
            end
            ST_BLANK: begin
                if (!cmd_eff)
                    r_d.st = ST_OFF;
                else if (tmr_cnt == TW'(BLANK_CYC - 1))
                    r_d.st = ST_ON;
            end
            ST_ON: begin
                if (desat_valid) begin
                    r_d.st      = ST_SSD;
                    tmr_restart = 1'b1;
                end else if (!cmd_eff) begin
                    r_d.st = ST_OFF;
                end
            end
            ST_SSD: begin
                if (tmr_cnt == TW'(SSD_CYC - 1)) begin
                    r_d.st   = ST_LATCH;
                    r_d.done = 1'b1;
                end
            end
            ST_LATCH: begin
                if (fault_clr)
                    r_d.st = ST_OFF;
            end
            default: r_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_OFF;
            r_q.cmd_hold <= 1'b0;
            r_q.done     <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_main_en  = (r_q.st == ST_BLANK) || (r_q.st == ST_ON);
    assign src_boost_en = (r_q.st == ST_BLANK) && (tmr_cnt < TW'(BOOST_CYC));
    assign snk_main_en  = (r_q.st == ST_OFF) || (r_q.st == ST_LATCH);
    assign soft_off_en  = (r_q.st == ST_SSD);
    assign ssd_active_n = (r_q.st != ST_SSD);
    assign ssd_done     = r_q.done;
endmodule

// File: rtl/desat_ssd_channel_chk.sv
`timescale 1ns/1ps
module desat_ssd_channel_chk #(
    parameter int SSD_CYC = 2312,
    localparam int LW = $clog2(SSD_CYC + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic gate_on,
    input logic freeze,
    input logic src_main_en,
    input logic src_boost_en,
    input logic snk_main_en,
    input logic soft_off_en,
    input logic ssd_active_n,
    input logic ssd_done
);
    logic [LW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            len_q <= '0;
        else if (!soft_off_en)
            len_q <= '0;
        else if (len_q != {LW{1'b1}})
            len_q <= len_q + 1'b1;
    end

    a_r6_main_stages_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        soft_off_en |-> (!src_main_en && !snk_main_en && !src_boost_en));

    a_r6_sync_low_only_in_ssd: assert property (@(posedge clk) disable iff (!rst_n)
        !ssd_active_n |-> soft_off_en);

    a_r2_boost_needs_main: assert property (@(posedge clk) disable iff (!rst_n)
        src_boost_en |-> src_main_en);

    a_r3_no_event_after_boost: assert property (@(posedge clk) disable iff (!rst_n)
        src_boost_en |=> !soft_off_en);

    a_r4_off_no_event: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_main_en && !gate_on && !freeze) |=> !soft_off_en);

    a_r7_done_follows_ssd: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_done |-> ($past(soft_off_en) && snk_main_en));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_done |=> !ssd_done);

    a_r10_ssd_full_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_off_en) |-> (len_q == LW'(SSD_CYC)));
endmodule

bind desat_ssd_channel desat_ssd_channel_chk #(.SSD_CYC(SSD_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_on      (gate_on),
    .freeze       (freeze),
    .src_main_en  (src_main_en),
    .src_boost_en (src_boost_en),
    .snk_main_en  (snk_main_en),
    .soft_off_en  (soft_off_en),
    .ssd_active_n (ssd_active_n),
    .ssd_done     (ssd_done)
);

// File: tb/desat_ssd_channel_tb.sv
`timescale 1ns/1ps
module desat_ssd_channel_tb;
    localparam int BOOST = 3;
    localparam int BLANK = 10;
    localparam int FILT  = 4;
    localparam int SSD   = 12;

    // observed vector: {src_main, src_boost, snk_main, soft_off, ssd_active_n, ssd_done}
    localparam logic [5:0] V_OFF  = 6'b001010;
    localparam logic [5:0] V_ONB  = 6'b110010;
    localparam logic [5:0] V_ON   = 6'b100010;
    localparam logic [5:0] V_SSD  = 6'b000100;
    localparam logic [5:0] V_DONE = 6'b001011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_on = 1'b0, desat_raw = 1'b0, freeze = 1'b0, fault_clr = 1'b0;
    logic src_main_en, src_boost_en, snk_main_en, soft_off_en, ssd_active_n, ssd_done;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    desat_ssd_channel #(
        .BOOST_CYC(BOOST), .BLANK_CYC(BLANK), .FILT_CYC(FILT), .SSD_CYC(SSD)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .desat_raw(desat_raw),
        .freeze(freeze), .fault_clr(fault_clr),
        .src_main_en(src_main_en), .src_boost_en(src_boost_en),
        .snk_main_en(snk_main_en), .soft_off_en(soft_off_en),
        .ssd_active_n(ssd_active_n), .ssd_done(ssd_done)
    );

    function automatic logic [5:0] obs();
        return {src_main_en, src_boost_en, snk_main_en, soft_off_en, ssd_active_n, ssd_done};
    endfunction

    // monitor: compares the outputs after each edge with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (obs() !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %b expected %b at %0t", it.tag, obs(), it.exp, $time);
                end
            end
        end
    end

    // driver: set inputs before an edge and queue the outputs expected after it
    task automatic step(input logic g, input logic d, input logic f, input logic c,
                        input logic [5:0] e, input string tag);
        @(negedge clk);
        gate_on = g; desat_raw = d; freeze = f; fault_clr = c;
        sb_q.push_back('{e, tag});
    endtask

    task automatic turn_on(input logic d, input string tag);
        for (int i = 0; i < BOOST; i++) step(1, d, 0, 0, V_ONB, {tag, " R2 boost"});
        for (int i = BOOST; i < BLANK + FILT; i++) step(1, d, 0, 0, V_ON, {tag, " R3 blank/on"});
    endtask

    task automatic finish_ssd(input logic f);
        for (int i = 1; i < SSD; i++) step(0, 0, f, 0, V_SSD, "R6 soft-off");
        step(0, 0, f, 0, V_DONE, "R7 done pulse");
        step(0, 0, 0, 1, V_OFF, "R7 clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        total++;
        if (obs() !== V_OFF) begin
            bad++;
            $display("FAIL R1 reset: got %b expected %b", obs(), V_OFF);
        end
        step(0, 0, 0, 0, V_OFF, "R1 idle");
        step(0, 0, 0, 0, V_OFF, "R1 idle");

        // R4: desat high while off
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, V_OFF, "R4 desat while off");

        // R2/R3/R6/R10/R7: desat high from turn-on
        turn_on(1, "T2");
        step(1, 1, 0, 0, V_SSD, "R3 first soft-off edge");
        step(1, 1, 0, 0, V_SSD, "R6");
        step(1, 0, 0, 0, V_SSD, "R6");
        step(0, 0, 0, 0, V_SSD, "R10 gate low in soft-off");
        step(0, 0, 0, 0, V_SSD, "R10");
        step(0, 0, 0, 1, V_SSD, "R7 clear ignored in soft-off");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, V_SSD, "R6 hiz");
        step(1, 0, 0, 0, V_DONE, "R7 done pulse");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, V_OFF, "R7 latched ignores gate");
        step(0, 0, 0, 1, V_OFF, "R7 clear");
        step(0, 0, 0, 0, V_OFF, "R7 off after clear");
        step(1, 0, 0, 0, V_ONB, "R7 turn-on after clear");
        step(0, 0, 0, 0, V_OFF, "R9 abort");

        // R9: drop during blanking, then restart blanking
        for (int i = 0; i < BOOST; i++) step(1, 1, 0, 0, V_ONB, "R9 first pulse");
        step(1, 1, 0, 0, V_ON, "R9 first pulse");
        step(1, 1, 0, 0, V_ON, "R9 first pulse");
        step(0, 1, 0, 0, V_OFF, "R9 drop in blanking");
        step(0, 1, 0, 0, V_OFF, "R9 no event");
        turn_on(1, "R9 restart");
        step(1, 1, 0, 0, V_SSD, "R3 restarted blanking");
        finish_ssd(0);

        // R5: short pulses discarded, full-width run accepted
        turn_on(0, "T4");
        for (int i = 0; i < FILT - 1; i++) step(1, 1, 0, 0, V_ON, "R5 short pulse");
        step(1, 0, 0, 0, V_ON, "R5 gap");
        for (int i = 0; i < FILT - 1; i++) step(1, 1, 0, 0, V_ON, "R5 short pulse");
        step(1, 0, 0, 0, V_ON, "R5 gap");
        for (int i = 0; i < FILT - 1; i++) step(1, 1, 0, 0, V_ON, "R5 run");
        step(1, 1, 0, 0, V_SSD, "R5 full width accepted");
        finish_ssd(0);

        // R8: freeze holds on, desat still acts
        turn_on(0, "T5");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 0, V_ON, "R8 frozen on");
        for (int i = 0; i < FILT - 1; i++) step(0, 1, 1, 0, V_ON, "R8 frozen desat");
        step(0, 1, 1, 0, V_SSD, "R8 desat while frozen");
        finish_ssd(1);
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, V_OFF, "R8 frozen off");
        step(1, 0, 0, 0, V_ONB, "R8 release");
        step(0, 0, 0, 0, V_OFF, "R8 off");

        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule